// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Its index space has two parts. A static part sits at the low indices and always maps straight through. Above it sits a rotating part whose indices are renamed each loop iteration by a rotation base.

A rotating logical index is offset into the rotating part and the base is added to it. The sum wraps at the size of the rotating part, and that gives the physical register. At the end of each iteration a rotate strobe steps the base down by one. A loop-carried value therefore keeps the same logical name in every iteration, yet each iteration writes it into a fresh physical register.

The renaming is fully under software control. There is no dependence tracking and no rename table. A clear input puts the base back at zero before a loop starts. The file has two combinational read ports and one write port, and a same-cycle write is forwarded to the read ports.

Top module: `rot_regfile`

## Requirements
- R1: After reset (rst_n low at a clock edge) every register reads 0 and the rotation base is 0.
- R2: A logical index below STATIC_REGS addresses the physical register with the same index, whatever the rotation base.
- R3: A logical index l with STATIC_REGS <= l < STATIC_REGS+ROT_REGS addresses physical register STATIC_REGS + ((l - STATIC_REGS + base) mod ROT_REGS).
- R4: A rotate pulse without clear lowers the base by one at the clock edge. From 0 the base wraps to ROT_REGS-1.
- R5: A write that shares its cycle with a rotate pulse is mapped with the base from before that rotation.
- R6: rrbClear sets the base to 0 at the clock edge and takes priority over a rotate pulse in the same cycle.
- R7: Both read ports are combinational and independent: each returns the current contents of the register that its own address maps to.
- R8: When a read port addresses the same logical index as an enabled in-range write in the same cycle, the port returns wrData in that cycle.
- R9: An index at or above STATIC_REGS+ROT_REGS is out of range. A write to it changes no register, and a read of it returns 0.
- R10: After a rotate pulse with no write, the value held at rotating logical index l is found at l+1. The value held at the top rotating index is found at STATIC_REGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rotate | input | 1 | Loop-end strobe that steps the rotation base down |
| rrbClear | input | 1 | Sets the rotation base to zero |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W | Logical write index |
| wrData | input | DATA_W | Write data |
| rdAddrA | input | ADDR_W | Logical index of read port A |
| rdDataA | output | DATA_W | Read data of port A |
| rdAddrB | input | ADDR_W | Logical index of read port B |
| rdDataB | output | DATA_W | Read data of port B |

## Verification
The bench builds the file with two static registers, a rotating part of five registers and 8-bit data. Five is not a power of two, so the wrap in the index sum goes through the compare-and-subtract path. The 3-bit index then also leaves one out-of-range address, 7. At this size a few sweeps read every logical index on both ports at every one of the five base values, including the wrap from 0 to 4. The rotate-with-write, clear-over-rotate and forwarding cases are reached in a few hundred cycles.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic wrCommit;   // in-range write is enabled this cycle
    logic rdValidA;   // port A index is in range
    logic rdValidB;   // port B index is in range
  } rrfStrobe_t;
endpackage

// File: rtl/rrf_ctrl.sv
module rrf_ctrl #(
  parameter int STATIC_REGS = 8,
  parameter int ROT_REGS    = 16,
  parameter int ADDR_W      = 5,
  parameter int RRB_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rotate,
  input  logic                   rrbClear,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [ADDR_W-1:0]      rdAddrA,
  input  logic [ADDR_W-1:0]      rdAddrB,
  output rrf_pkg::rrfStrobe_t    strobes,
  output logic [RRB_W-1:0]       rrb
);
  localparam int TOTAL = STATIC_REGS + ROT_REGS;
  localparam int SUM_W = ADDR_W + 1;

  function automatic logic inRange(input logic [ADDR_W-1:0] idx);
    return SUM_W'(idx) < SUM_W'(TOTAL);
  endfunction

  // Rotation base: clear wins over rotate; wrap from 0 to ROT_REGS-1.
  always_ff @(posedge clk) begin
    if (!rst_n || rrbClear) begin
      rrb <= '0;
    end else if (rotate) begin
      if (rrb == '0) rrb <= RRB_W'(ROT_REGS - 1);
      else           rrb <= rrb - 1'b1;
    end
  end

  always_comb begin
    strobes.wrCommit = wrEn && inRange(wrAddr);
    strobes.rdValidA = inRange(rdAddrA);
    strobes.rdValidB = inRange(rdAddrB);
  end
endmodule

// File: rtl/rrf_datapath.sv
module rrf_datapath #(
  parameter int STATIC_REGS = 8,
  parameter int ROT_REGS    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int RRB_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rrf_pkg::rrfStrobe_t    strobes,
  input  logic [RRB_W-1:0]       rrb,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      rdAddrA,
  input  logic [ADDR_W-1:0]      rdAddrB,
  output logic [DATA_W-1:0]      rdDataA,
  output logic [DATA_W-1:0]      rdDataB
);
  localparam int TOTAL = STATIC_REGS + ROT_REGS;
  localparam int SUM_W = ADDR_W + 1;

  logic [DATA_W-1:0] regs [TOTAL];
  logic [ADDR_W-1:0] physW, physA, physB;

  // Logical to physical index: static part passes, rotating part wraps.
  function automatic logic [ADDR_W-1:0] physOf(input logic [ADDR_W-1:0] lidx,
                                               input logic [RRB_W-1:0]  base);
    logic [SUM_W-1:0] sum;
    if (SUM_W'(lidx) < SUM_W'(STATIC_REGS)) return lidx;
    sum = SUM_W'(lidx) - SUM_W'(STATIC_REGS) + SUM_W'(base);
    if (sum >= SUM_W'(ROT_REGS)) sum = sum - SUM_W'(ROT_REGS);
    sum = sum + SUM_W'(STATIC_REGS);
    return sum[ADDR_W-1:0];
  endfunction

  always_comb begin
    physW = physOf(wrAddr, rrb);
    physA = physOf(rdAddrA, rrb);
    physB = physOf(rdAddrB, rrb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) regs[i] <= '0;
    end else if (strobes.wrCommit) begin
      regs[physW] <= wrData;
    end
  end

  // Combinational reads with same-cycle write forwarding.
  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    if (strobes.rdValidA) begin
      if (strobes.wrCommit && physW == physA) rdDataA = wrData;
      else                                    rdDataA = regs[physA];
    end
    if (strobes.rdValidB) begin
      if (strobes.wrCommit && physW == physB) rdDataB = wrData;
      else                                    rdDataB = regs[physB];
    end
  end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int STATIC_REGS = 8,
  parameter int ROT_REGS    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = $clog2(STATIC_REGS + ROT_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rotate,
  input  logic              rrbClear,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int RRB_W = (ROT_REGS > 2) ? $clog2(ROT_REGS) : 1;

  rrf_pkg::rrfStrobe_t strobes;
  logic [RRB_W-1:0]    rrbCur;

  rrf_ctrl #(
    .STATIC_REGS(STATIC_REGS), .ROT_REGS(ROT_REGS),
    .ADDR_W(ADDR_W), .RRB_W(RRB_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .rotate(rotate), .rrbClear(rrbClear),
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .strobes(strobes), .rrb(rrbCur)
  );

  rrf_datapath #(
    .STATIC_REGS(STATIC_REGS), .ROT_REGS(ROT_REGS), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .RRB_W(RRB_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rrb(rrbCur),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: rtl/rrf_chk.sv
module rrf_chk #(
  parameter int STATIC_REGS = 8,
  parameter int ROT_REGS    = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int RRB_W       = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rotate,
  input logic              rrbClear,
  input logic [RRB_W-1:0]  rrb,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdDataB
);
  localparam int SUM_W = ADDR_W + 1;
  localparam int TOTAL = STATIC_REGS + ROT_REGS;

  // R1
  base_after_reset_chk: assert property (@(posedge clk) !rst_n |=> rrb == '0);

  // R4
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !rrbClear) |=>
      rrb == (($past(rrb) == '0) ? RRB_W'(ROT_REGS - 1) : $past(rrb) - 1'b1));

  // R4
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && !rrbClear) |=> $stable(rrb));

  // R4
  base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SUM_W'(rrb) < SUM_W'(ROT_REGS));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rrbClear |=> rrb == '0);

  // R8
  fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && SUM_W'(wrAddr) < SUM_W'(TOTAL) && rdAddrA == wrAddr) |-> rdDataA == wrData);

  // R8
  fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && SUM_W'(wrAddr) < SUM_W'(TOTAL) && rdAddrB == wrAddr) |-> rdDataB == wrData);

  // R9
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(rdAddrA) >= SUM_W'(TOTAL)) |-> rdDataA == '0);
endmodule

bind rot_regfile rrf_chk #(
  .STATIC_REGS(STATIC_REGS), .ROT_REGS(ROT_REGS), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .RRB_W(RRB_W)
) i_rrf_chk (
  .clk(clk), .rst_n(rst_n), .rotate(rotate), .rrbClear(rrbClear), .rrb(rrbCur),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
);

// File: tb/test_rot_regfile.sv
module test_rot_regfile;
  localparam int S = 2;
  localparam int R = 5;
  localparam int T = S + R;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rotate = 1'b0, rrbClear = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdDataA, rdDataB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mem [T];
  int mrrb = 0;
  logic [7:0] snap [8];

  always #10 clk = ~clk;

  rot_regfile #(.STATIC_REGS(S), .ROT_REGS(R), .DATA_W(8)) i_rot_regfile (
    .clk(clk), .rst_n(rst_n), .rotate(rotate), .rrbClear(rrbClear),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  function automatic int expPhys(input int l, input int base);
    if (l < S) return l;
    return S + ((l - S + base) % R);
  endfunction

  function automatic logic [7:0] expRead(input int l);
    if (l >= T) return 8'h00;
    return mem[expPhys(l, mrrb)];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (time %0t)", req, act, exp, $time);
    end
  endtask

  // Drive at negedge, advance to posedge, update model, return at negedge.
  task automatic step(input bit we, input int wa, input logic [7:0] wd,
                      input bit rot, input bit clr);
    wrEn = we; wrAddr = AW'(wa); wrData = wd; rotate = rot; rrbClear = clr;
    @(posedge clk);
    if (we && wa < T) mem[expPhys(wa, mrrb)] = wd;
    if (clr) mrrb = 0;
    else if (rot) mrrb = (mrrb == 0) ? R - 1 : mrrb - 1;
    @(negedge clk);
    wrEn = 1'b0; rotate = 1'b0; rrbClear = 1'b0;
  endtask

  // Read every logical index: A ascending, B descending.
  task automatic readAll(input string req);
    for (int l = 0; l < 8; l++) begin
      rdAddrA = AW'(l);
      rdAddrB = AW'(7 - l);
      #2;
      check(req, rdDataA, expRead(l));
      check(req, rdDataB, expRead(7 - l));
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < T; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    readAll("R1 reset");

    // Fill at base 0; R9 out-of-range write must touch nothing
    for (int l = 0; l < T; l++) step(1'b1, l, 8'h10 + 8'(l), 1'b0, 1'b0);
    step(1'b1, 7, 8'hEE, 1'b0, 1'b0);
    readAll("R9 oor write ignored / R2 R3 base0");

    // Sweep all base values including wrap 0 -> R-1
    for (int k = 0; k < 2 * R; k++) begin
      for (int l = 0; l < 8; l++) begin
        rdAddrA = AW'(l); #1; snap[l] = rdDataA;
      end
      step(1'b0, 0, 8'h00, 1'b1, 1'b0);
      // R10: value moves up one rotating index, top wraps to base of region
      for (int l = S; l < T; l++) begin
        rdAddrA = AW'((l == T - 1) ? S : l + 1);
        #1;
        check("R10 shift after rotate", rdDataA, snap[l]);
      end
      // R2: static indices unaffected by the base
      for (int l = 0; l < S; l++) begin
        rdAddrB = AW'(l); #1;
        check("R2 static bypass", rdDataB, snap[l]);
      end
      readAll("R3 R4 R7 mapping sweep");
      // R5: write together with rotate uses old base
      step(1'b1, S + (k % R), 8'h40 + 8'(k), 1'b1, 1'b0);
      readAll("R5 write with rotate");
    end

    // R8: forwarding on both ports, in and out of rotating region
    for (int l = 0; l < T; l++) begin
      wrEn = 1'b1; wrAddr = AW'(l); wrData = 8'hA0 + 8'(l);
      rdAddrA = AW'(l); rdAddrB = AW'(l);
      #2;
      check("R8 forward A", rdDataA, 8'hA0 + 8'(l));
      check("R8 forward B", rdDataB, 8'hA0 + 8'(l));
      step(1'b1, l, 8'hA0 + 8'(l), 1'b0, 1'b0);
    end
    readAll("R8 forwarded data committed");

    // R6: clear beats rotate
    step(1'b0, 0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 0, 8'h00, 1'b1, 1'b0);
    readAll("R3 before clear");
    step(1'b0, 0, 8'h00, 1'b1, 1'b1);
    readAll("R6 clear over rotate");
    step(1'b1, S + 1, 8'h77, 1'b0, 1'b1);
    readAll("R6 clear with write");

    // R1: reset again clears data and base
    step(1'b0, 0, 8'h00, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < T; i++) mem[i] = 8'h00;
    mrrb = 0;
    readAll("R1 second reset");
    step(1'b1, S, 8'h5C, 1'b0, 1'b0);
    rdAddrA = AW'(S); #2;
    check("R1 base zero after reset", rdDataA, 8'h5C);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule